// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block holds the 32-bit floating-point control and status word that sits beside an arithmetic datapath. Software loads it through a masked write port. The block decodes two mode controls from it: a rounding selection and a denormal flush enable. It also keeps the exception bookkeeping that follows each arithmetic operation.

When the datapath finishes an operation it strobes `op_done` and presents five raw exception bits. The block overwrites the per-operation flag field with those bits. When any bit is raised, it also ORs them into the sticky cause field. It then compares the resulting cause with the enable field. If they overlap, a one-cycle exception request leaves the block in that same cycle, together with a fixed vector code.

Top module: `fpsr_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word clears to zero, and `exc_req` is low after reset.
- R2: A write (`wr_en` high) stores `wr_data & 32'h003D_FFFF`. Bits 31:22 and bit 17 always read as zero.
- R3: `rnd_to_zero` is high exactly when bits [1:0] hold 2'b01. Every other encoding selects round-to-nearest-even, with `rnd_to_zero` low.
- R4: `flush_denorm` follows bit 18 of the status word.
- R5: On `op_done` without a write, the flag field [6:2] is replaced by `raw_exc` at the next edge, even when `raw_exc` is zero. The bit order is: `raw_exc[0]` inexact to bit 2, `[1]` underflow to bit 3, `[2]` overflow to bit 4, `[3]` divide-by-zero to bit 5, `[4]` invalid to bit 6.
- R6: On `op_done` with nonzero `raw_exc`, the cause field [16:12] becomes its old value ORed with `raw_exc`, in the same bit order as R5. With zero `raw_exc` the cause field is unchanged.
- R7: `exc_req` is high in an `op_done` cycle exactly when `raw_exc` is nonzero and `(old cause | raw_exc) & enables[11:7]` is nonzero. It is low in all other cycles.
- R8: `exc_vector` is 12'h120 while `exc_req` is high, and zero otherwise.
- R9: When `wr_en` and `op_done` occur in the same cycle, the register takes the masked write. `exc_req` is still evaluated from the word held before that edge.
- R10: An operation leaves the rounding, enable, flush and spare writable bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write value |
| op_done | input | 1 | Operation-complete strobe from the datapath |
| raw_exc | input | 5 | Raw exception bits of the finished operation |
| csr_q | output | 32 | Current status word |
| rnd_to_zero | output | 1 | High selects truncation rounding |
| flush_denorm | output | 1 | Denormal flush-to-zero enable |
| exc_req | output | 1 | One-cycle exception request |
| exc_vector | output | 12 | Vector code accompanying the request |

## Verification
All 32 raw-exception patterns are swept under several enable masks: none, all, only the lowest kind, only the highest kind, and an alternating mix. This separates correct per-bit cause/enable matching from a request raised on any flag or none. A second operation after each sweep step, without clearing cause, checks that cause accumulates while flags are replaced, and that a zero-flag operation stays silent even with stale enabled cause bits. All four rounding encodings, the mask over every bit lane, and a write colliding with an operation are each tried separately.

// File: rtl/fpsr_pkg.sv
// Package: field positions, masks and codes of the floating-point status word.
// Assumes a 32-bit word and five exception kinds.
package fpsr_pkg;
    localparam int CSR_W    = 32;
    localparam int NEXC     = 5;
    localparam int RM_W     = 2;
    localparam int RM_LO    = 0;
    localparam int FLAG_LO  = 2;
    localparam int EN_LO    = FLAG_LO + NEXC;
    localparam int CAUSE_LO = EN_LO + NEXC;
    localparam int FTZ_BIT  = 18;
    localparam int VEC_W    = 12;
    localparam logic [RM_W-1:0]  RM_TRUNC = 2'b01;
    localparam logic [VEC_W-1:0] EXC_VEC  = 12'h120;
    localparam logic [CSR_W-1:0] WR_MASK  = 32'h003D_FFFF;
endpackage

// File: rtl/fpsr_mode_dec.sv
// Mode decoder: turns the rounding field and flush bit into datapath controls.
// Assumes only the truncation encoding selects round-toward-zero.
module fpsr_mode_dec
    import fpsr_pkg::*;
(
    input  logic [RM_W-1:0] rm_field,
    input  logic            ftz_bit,
    output logic            rnd_to_zero,
    output logic            flush_denorm
);
    // Decode the rounding field; every other value means nearest-even.
    always_comb begin
        rnd_to_zero  = (rm_field == RM_TRUNC);
        flush_denorm = ftz_bit;
    end

    // p_rtz_decode_r3: immediate check of the decode.
    always_comb begin
        p_rtz_decode_r3: assert (rnd_to_zero == (rm_field == 2'b01));
    end
endmodule

// File: rtl/fpsr_exc_eval.sv
// Exception evaluator: builds the post-operation status word and the trap.
// Assumes raw_exc is valid only while op_done is high.
module fpsr_exc_eval
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CSR_W-1:0] csr,
    input  logic             op_done,
    input  logic [NEXC-1:0]  raw_exc,
    output logic [CSR_W-1:0] nxt_csr,
    output logic             trap
);
    logic [NEXC-1:0] cause_cur;
    logic [NEXC-1:0] en_cur;
    logic [NEXC-1:0] hit;
    logic            any_raw;

    // Split the stored word into its exception fields.
    always_comb begin
        cause_cur = csr[CAUSE_LO +: NEXC];
        en_cur    = csr[EN_LO +: NEXC];
        any_raw   = |raw_exc;
    end

    // One match lane per exception kind: enabled and present in the new cause.
    for (genvar i = 0; i < NEXC; i++) begin : g_lane
        assign hit[i] = (cause_cur[i] | raw_exc[i]) & en_cur[i];
    end

    // Next word: flags replaced every time, cause accumulated only when raised.
    always_comb begin
        nxt_csr = csr;
        nxt_csr[FLAG_LO +: NEXC] = raw_exc;
        if (any_raw) begin
            nxt_csr[CAUSE_LO +: NEXC] = cause_cur | raw_exc;
        end
    end

    // Trap request exists only in an operation cycle that raised something.
    always_comb begin
        trap = op_done && any_raw && (|hit);
    end

    // p_trap_needs_op_r7: no request without a completed operation.
    p_trap_needs_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (op_done && raw_exc != '0));
    // p_trap_enabled_r7: a request implies some enable bit is set.
    p_trap_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (csr[11:7] != '0));
endmodule

// File: rtl/fpsr_store.sv
// Status register: masked software write wins over the operation update.
// Assumes the update word is only applied in op_done cycles.
module fpsr_store
    import fpsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             op_done,
    input  logic [CSR_W-1:0] nxt_csr,
    output logic [CSR_W-1:0] csr_q
);
    // Hold the status word with priority reset > write > operation update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else if (wr_en) begin
            csr_q <= wr_data & WR_MASK;
        end else if (op_done) begin
            csr_q <= nxt_csr;
        end
    end

    // p_rsvd_zero_r2: reserved bits never become visible.
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q[31:22] == '0) && !csr_q[17]);
    // p_cause_sticky_r6: an operation never clears a cause bit.
    p_cause_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_done && !wr_en)) |->
        ((csr_q[16:12] & $past(csr_q[16:12])) == $past(csr_q[16:12])));
    // p_modes_kept_r10: an operation keeps mode and enable bits.
    p_modes_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_done && !wr_en)) |->
        (csr_q[11:7] == $past(csr_q[11:7]) && csr_q[1:0] == $past(csr_q[1:0])
         && csr_q[21:18] == $past(csr_q[21:18])));
endmodule

// File: rtl/fpsr_ctrl.sv
// Top: floating-point status word, mode outputs and exception request.
// Assumes op_done and raw_exc come from the datapath in the same cycle.
module fpsr_ctrl
    import fpsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              op_done,
    input  logic [4:0]        raw_exc,
    output logic [31:0]       csr_q,
    output logic              rnd_to_zero,
    output logic              flush_denorm,
    output logic              exc_req,
    output logic [11:0]       exc_vector
);
    logic [CSR_W-1:0] nxt_csr;
    logic             trap;

    fpsr_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .op_done (op_done),
        .nxt_csr (nxt_csr),
        .csr_q   (csr_q)
    );

    fpsr_exc_eval u_eval (
        .clk     (clk),
        .rst_n   (rst_n),
        .csr     (csr_q),
        .op_done (op_done),
        .raw_exc (raw_exc),
        .nxt_csr (nxt_csr),
        .trap    (trap)
    );

    fpsr_mode_dec u_mode (
        .rm_field     (csr_q[RM_LO +: RM_W]),
        .ftz_bit      (csr_q[FTZ_BIT]),
        .rnd_to_zero  (rnd_to_zero),
        .flush_denorm (flush_denorm)
    );

    // Drive the request and its vector code together.
    always_comb begin
        exc_req    = trap;
        exc_vector = trap ? EXC_VEC : '0;
    end

    // p_vector_code_r8: the vector is the fixed code exactly while requesting.
    p_vector_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req ? (exc_vector == 12'h120) : (exc_vector == '0));
    // p_ftz_follow_r4: flush control tracks the stored bit.
    p_ftz_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_denorm == csr_q[18]);
endmodule

// File: tb/sim_fpsr_ctrl.sv
module sim_fpsr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        op_done = 1'b0;
    logic [4:0]  raw_exc = '0;
    logic [31:0] csr_q;
    logic        rnd_to_zero, flush_denorm, exc_req;
    logic [11:0] exc_vector;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] m;   // bench model of the status word

    always #4 clk = ~clk;   // 125 MHz

    fpsr_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .op_done(op_done), .raw_exc(raw_exc), .csr_q(csr_q),
        .rnd_to_zero(rnd_to_zero), .flush_denorm(flush_denorm),
        .exc_req(exc_req), .exc_vector(exc_vector));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_trap(input logic [31:0] w, input logic [4:0] r);
        return (r != 0) && ((((w[16:12] | r) & w[11:7])) != 0);
    endfunction

    // Masked write; checks stored word and mode outputs (R2, R3, R4).
    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        m = v & 32'h003D_FFFF;
        #1;
        chk(csr_q == m, "R2", csr_q, m);
        chk(rnd_to_zero == (m[1:0] == 2'b01), "R3", {31'b0, rnd_to_zero}, {31'b0, m[1:0] == 2'b01});
        chk(flush_denorm == m[18], "R4", {31'b0, flush_denorm}, {31'b0, m[18]});
    endtask

    // One operation; checks request in-cycle (R7, R8), word after edge (R5, R6, R10).
    task automatic do_op(input logic [4:0] r);
        bit t;
        logic [31:0] e;
        @(negedge clk);
        op_done = 1'b1; raw_exc = r;
        #1;
        t = exp_trap(m, r);
        chk(exc_req == t, "R7", {31'b0, exc_req}, {31'b0, t});
        chk(exc_vector == (t ? 12'h120 : 12'h000), "R8", {20'b0, exc_vector}, t ? 32'h120 : 32'h0);
        @(negedge clk);
        op_done = 1'b0; raw_exc = '0;
        e = m;
        e[6:2] = r;
        if (r != 0) e[16:12] = m[16:12] | r;
        m = e;
        #1;
        chk(csr_q[6:2] == e[6:2], "R5", csr_q, e);
        chk(csr_q[16:12] == e[16:12], "R6", csr_q, e);
        chk(csr_q == e, "R10", csr_q, e);
        chk(exc_req == 1'b0, "R7 pulse", {31'b0, exc_req}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] ens [5] = '{5'h00, 5'h1F, 5'h01, 5'h10, 5'h0A};
        repeat (3) @(negedge clk);
        #1;
        chk(csr_q == 0, "R1", csr_q, 0);
        chk(exc_req == 1'b0, "R1", {31'b0, exc_req}, 0);
        rst_n = 1'b1;

        // R2: mask over all lanes, then zero.
        do_write(32'hFFFF_FFFF);
        do_write(32'h0000_0000);
        // R3/R4: every rounding encoding with flush toggled.
        for (int k = 0; k < 4; k++) do_write({13'b0, k[0], 16'b0, k[1:0]});

        // R5..R8: sweep all raw patterns under several enable masks, twice.
        foreach (ens[j]) begin
            for (int r = 0; r < 32; r++) begin
                do_write({20'b0, ens[j], 7'b0} | 32'h1);
                do_op(r[4:0]);
                do_op(5'(r * 7 + 3));
                do_op(5'h00);   // R6: silent with stale cause
            end
        end

        // R9: write and operation in the same cycle.
        do_write(32'h0000_0F80);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0004_0002; op_done = 1'b1; raw_exc = 5'h04;
        #1;
        chk(exc_req == 1'b1, "R9", {31'b0, exc_req}, 1);
        @(negedge clk);
        wr_en = 1'b0; op_done = 1'b0; raw_exc = '0;
        #1;
        chk(csr_q == 32'h0004_0002, "R9", csr_q, 32'h0004_0002);

        // R1: reset after activity.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        chk(csr_q == 0, "R1", csr_q, 0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule